// File: doc/BRIEF.md
# Read/Write Bus Turnaround Arbiter

This block decides, cycle by cycle, whether a memory data bus serves reads or writes. It watches how full the read queue and the write queue are and moves through four named states: `ST_READ`, `ST_RD2WR`, `ST_WRITE` and `ST_WR2RD`. Each change of direction passes through a turnaround state that holds the bus idle for a set number of clock cycles. The read-to-write gap and the write-to-read gap are separate parameters.

In the read state, reads are granted until one of two things happens. Either the write queue climbs to a high watermark, or the read queue runs dry while writes are waiting. Once in the write state, the block stays there until three conditions hold together: a minimum batch of writes has been issued, the write queue has fallen to a low watermark, and reads are waiting. If the write queue empties while reads wait, the block leaves at once. Two phase counters track the reads and the writes issued in the current phase. A downstream scheduler uses the grant strobe to pick a request, and it answers with an issue acknowledge when it sends one.

The transitions are as follows. `ST_READ` goes to `ST_RD2WR` on a write switch. `ST_RD2WR` goes to `ST_WRITE` when its gap ends. `ST_WRITE` goes to `ST_WR2RD` on a read switch. `ST_WR2RD` goes to `ST_READ` when its gap ends.

Top module: `rw_turn_arbiter`

## Requirements
- R1: After reset the direction is `ST_READ`, both phase counters read 0 and the busy flag is low.
- R2: `bus_dir` carries the state as a code: `ST_READ`=0, `ST_RD2WR`=1, `ST_WRITE`=2, `ST_WR2RD`=3.
- R3: In `ST_READ`, `grant_rd` is high when `rd_occ` is non-zero and no write switch is due. `grant_wr` is never high outside `ST_WRITE`, and the two grants are never high together.
- R4: In `ST_READ`, when `wr_occ` >= `WR_HI`, `grant_rd` is low in that cycle and the next state is `ST_RD2WR`, even with reads pending.
- R5: In `ST_READ`, when `rd_occ` is 0 and `wr_occ` is non-zero, the next state is `ST_RD2WR`, even below `WR_HI`.
- R6: `ST_RD2WR` lasts exactly `RTW_CYC` cycles and is followed by `ST_WRITE`. During those cycles `turn_busy` is high and no grant is given.
- R7: In `ST_WRITE`, `grant_wr` is high when `wr_occ` is non-zero and no read switch is due.
- R8: `ST_WRITE` switches to `ST_WR2RD` only when `rd_occ` is non-zero and one of two conditions holds: `wr_occ` is 0, or (`wr_cnt` >= `MIN_WR_BATCH` and `wr_occ` <= `WR_LO`). When the switch is due, `grant_wr` is low. In every other case the state stays `ST_WRITE`.
- R9: `ST_WR2RD` lasts exactly `WTR_CYC` cycles, with `turn_busy` high and no grant, and is followed by `ST_READ`.
- R10: A phase counter advances by one on an acknowledge that comes in the same cycle as its grant, and saturates at its maximum. An acknowledge without a grant is ignored. `rd_cnt` clears on entry to `ST_READ` and `wr_cnt` clears on entry to `ST_WRITE`. Each counter holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_occ | input | RQ_OCC_W | Read queue occupancy |
| wr_occ | input | WQ_OCC_W | Write queue occupancy |
| rd_ack | input | 1 | A read was issued this cycle |
| wr_ack | input | 1 | A write was issued this cycle |
| bus_dir | output | 2 | Current state code (R2) |
| grant_rd | output | 1 | Read issue permitted this cycle |
| grant_wr | output | 1 | Write issue permitted this cycle |
| turn_busy | output | 1 | Bus in a turnaround gap |
| rd_cnt | output | CNT_W | Reads issued in the current phase |
| wr_cnt | output | CNT_W | Writes issued in the current phase |

## Verification
The grants are combinational in the registered state and the present occupancies, so each is due in the same cycle the inputs are applied. A state change and a counter update show one clock edge later. A turnaround ends exactly `RTW_CYC` or `WTR_CYC` edges after the state is entered. The bench drives the inputs at the falling edge, compares all outputs 1 ns later, and then lets one rising edge pass. Each expected row therefore describes the state that the previous rows produced, and the rows are counted out edge by edge through every turnaround.

// File: rtl/rwta_pkg.sv
package rwta_pkg;

    typedef enum logic [1:0] {
        ST_READ  = 2'd0,
        ST_RD2WR = 2'd1,
        ST_WRITE = 2'd2,
        ST_WR2RD = 2'd3
    } bus_state_e;

endpackage

// File: rtl/rwta_turn_timer.sv
module rwta_turn_timer #(
    parameter int TMR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    output logic             last
);

    logic [TMR_W-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= load_val;
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign last = (remain_q == TMR_W'(1));

endmodule

// File: rtl/rwta_phase_ctr.sv
module rwta_phase_ctr #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc && (cnt != CNT_MAX)) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/rwta_fsm.sv
module rwta_fsm
    import rwta_pkg::*;
#(
    parameter int RQ_OCC_W     = 5,
    parameter int WQ_OCC_W     = 5,
    parameter int CNT_W        = 6,
    parameter int TMR_W        = 3,
    parameter int WR_HI        = 12,
    parameter int WR_LO        = 4,
    parameter int MIN_WR_BATCH = 3,
    parameter int RTW_CYC      = 2,
    parameter int WTR_CYC      = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [RQ_OCC_W-1:0] rd_occ,
    input  logic [WQ_OCC_W-1:0] wr_occ,
    input  logic                rd_ack,
    input  logic                wr_ack,
    input  logic [CNT_W-1:0]    wr_cnt,
    input  logic                tmr_last,
    output bus_state_e          state,
    output logic                grant_rd,
    output logic                grant_wr,
    output logic                turn_busy,
    output logic                tmr_load,
    output logic [TMR_W-1:0]    tmr_val,
    output logic                rd_clr,
    output logic                wr_clr,
    output logic                rd_inc,
    output logic                wr_inc
);

    localparam logic [WQ_OCC_W-1:0] HI_MARK   = WQ_OCC_W'(WR_HI);
    localparam logic [WQ_OCC_W-1:0] LO_MARK   = WQ_OCC_W'(WR_LO);
    localparam logic [CNT_W-1:0]    BATCH_MIN = CNT_W'(MIN_WR_BATCH);

    bus_state_e state_nxt;
    logic       rd_pend;
    logic       wr_pend;
    logic       go_write;
    logic       go_read;

    assign rd_pend  = (rd_occ != '0);
    assign wr_pend  = (wr_occ != '0);
    assign go_write = (wr_occ >= HI_MARK) || (!rd_pend && wr_pend);
    assign go_read  = rd_pend && (!wr_pend ||
                      ((wr_cnt >= BATCH_MIN) && (wr_occ <= LO_MARK)));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_READ;
        end else begin
            state <= state_nxt;
        end
    end

    // next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_READ:  if (go_write) state_nxt = ST_RD2WR;
            ST_RD2WR: if (tmr_last) state_nxt = ST_WRITE;
            ST_WRITE: if (go_read)  state_nxt = ST_WR2RD;
            ST_WR2RD: if (tmr_last) state_nxt = ST_READ;
            default:  state_nxt = ST_READ;
        endcase
    end

    // outputs
    always_comb begin
        grant_rd  = 1'b0;
        grant_wr  = 1'b0;
        turn_busy = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        rd_clr    = 1'b0;
        wr_clr    = 1'b0;
        unique case (state)
            ST_READ: begin
                grant_rd = rd_pend && !go_write;
                tmr_load = go_write;
                tmr_val  = TMR_W'(RTW_CYC);
            end
            ST_RD2WR: begin
                turn_busy = 1'b1;
                wr_clr    = tmr_last;
            end
            ST_WRITE: begin
                grant_wr = wr_pend && !go_read;
                tmr_load = go_read;
                tmr_val  = TMR_W'(WTR_CYC);
            end
            ST_WR2RD: begin
                turn_busy = 1'b1;
                rd_clr    = tmr_last;
            end
            default: begin
                turn_busy = 1'b0;
            end
        endcase
        rd_inc = grant_rd && rd_ack;
        wr_inc = grant_wr && wr_ack;
    end

endmodule

// File: rtl/rw_turn_arbiter.sv
module rw_turn_arbiter
    import rwta_pkg::*;
#(
    parameter int RQ_DEPTH     = 16,
    parameter int WQ_DEPTH     = 16,
    parameter int WR_HI        = 12,
    parameter int WR_LO        = 4,
    parameter int MIN_WR_BATCH = 3,
    parameter int RTW_CYC      = 2,
    parameter int WTR_CYC      = 3,
    parameter int CNT_W        = 6,
    localparam int RQ_OCC_W    = $clog2(RQ_DEPTH + 1),
    localparam int WQ_OCC_W    = $clog2(WQ_DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [RQ_OCC_W-1:0] rd_occ,
    input  logic [WQ_OCC_W-1:0] wr_occ,
    input  logic                rd_ack,
    input  logic                wr_ack,
    output logic [1:0]          bus_dir,
    output logic                grant_rd,
    output logic                grant_wr,
    output logic                turn_busy,
    output logic [CNT_W-1:0]    rd_cnt,
    output logic [CNT_W-1:0]    wr_cnt
);

    localparam int GAP_MAX = (RTW_CYC > WTR_CYC) ? RTW_CYC : WTR_CYC;
    localparam int TMR_W   = $clog2(GAP_MAX + 1);

    bus_state_e       state;
    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_last;
    logic             rd_clr;
    logic             wr_clr;
    logic             rd_inc;
    logic             wr_inc;

    rwta_fsm #(
        .RQ_OCC_W    (RQ_OCC_W),
        .WQ_OCC_W    (WQ_OCC_W),
        .CNT_W       (CNT_W),
        .TMR_W       (TMR_W),
        .WR_HI       (WR_HI),
        .WR_LO       (WR_LO),
        .MIN_WR_BATCH(MIN_WR_BATCH),
        .RTW_CYC     (RTW_CYC),
        .WTR_CYC     (WTR_CYC)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_occ   (rd_occ),
        .wr_occ   (wr_occ),
        .rd_ack   (rd_ack),
        .wr_ack   (wr_ack),
        .wr_cnt   (wr_cnt),
        .tmr_last (tmr_last),
        .state    (state),
        .grant_rd (grant_rd),
        .grant_wr (grant_wr),
        .turn_busy(turn_busy),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .rd_clr   (rd_clr),
        .wr_clr   (wr_clr),
        .rd_inc   (rd_inc),
        .wr_inc   (wr_inc)
    );

    rwta_turn_timer #(.TMR_W(TMR_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .last    (tmr_last)
    );

    rwta_phase_ctr #(.CNT_W(CNT_W)) u_rd_ctr (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (rd_clr),
        .inc  (rd_inc),
        .cnt  (rd_cnt)
    );

    rwta_phase_ctr #(.CNT_W(CNT_W)) u_wr_ctr (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (wr_clr),
        .inc  (wr_inc),
        .cnt  (wr_cnt)
    );

    assign bus_dir = state;

endmodule

// File: rtl/rwta_checker.sv
module rwta_checker #(
    parameter int RQ_OCC_W = 5,
    parameter int WQ_OCC_W = 5,
    parameter int CNT_W    = 6,
    parameter int WR_HI    = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic [RQ_OCC_W-1:0] rd_occ,
    input logic [WQ_OCC_W-1:0] wr_occ,
    input logic                rd_ack,
    input logic                wr_ack,
    input logic [1:0]          bus_dir,
    input logic                grant_rd,
    input logic                grant_wr,
    input logic                turn_busy,
    input logic [CNT_W-1:0]    rd_cnt,
    input logic [CNT_W-1:0]    wr_cnt
);

    localparam logic [1:0] C_RD  = 2'd0;
    localparam logic [1:0] C_R2W = 2'd1;
    localparam logic [1:0] C_WR  = 2'd2;
    localparam logic [1:0] C_W2R = 2'd3;
    localparam logic [WQ_OCC_W-1:0] HI_MARK = WQ_OCC_W'(WR_HI);

    AST_GRANT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_rd && grant_wr)); // R3

    AST_WR_GRANT_ONLY_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        grant_wr |-> (bus_dir == C_WR)); // R3

    AST_BUSY_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        turn_busy |-> (!grant_rd && !grant_wr)); // R6

    AST_HI_BLOCKS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_dir == C_RD) && (wr_occ >= HI_MARK)) |-> !grant_rd); // R4

    AST_HI_SWITCHES: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_dir == C_RD) && (wr_occ >= HI_MARK)) |=> (bus_dir == C_R2W)); // R4

    AST_RD2WR_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_dir == C_R2W) |=> ((bus_dir == C_R2W) || (bus_dir == C_WR))); // R6

    AST_WR2RD_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_dir == C_W2R) |=> ((bus_dir == C_W2R) || (bus_dir == C_RD))); // R9

    AST_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_dir == C_WR) && (rd_occ == '0)) |=> (bus_dir == C_WR)); // R8

    AST_RDCNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_dir == C_RD) && !(grant_rd && rd_ack)) |=> $stable(rd_cnt)); // R10

    AST_WRCNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_dir == C_WR) && !(grant_wr && wr_ack)) |=> $stable(wr_cnt)); // R10

endmodule

bind rw_turn_arbiter rwta_checker #(
    .RQ_OCC_W(RQ_OCC_W),
    .WQ_OCC_W(WQ_OCC_W),
    .CNT_W   (CNT_W),
    .WR_HI   (WR_HI)
) u_rwta_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_occ   (rd_occ),
    .wr_occ   (wr_occ),
    .rd_ack   (rd_ack),
    .wr_ack   (wr_ack),
    .bus_dir  (bus_dir),
    .grant_rd (grant_rd),
    .grant_wr (grant_wr),
    .turn_busy(turn_busy),
    .rd_cnt   (rd_cnt),
    .wr_cnt   (wr_cnt)
);

// File: tb/rw_turn_arbiter_bench.sv
module rw_turn_arbiter_bench;

    localparam int CNT_W = 6;

    typedef struct packed {
        logic [4:0]       rd;
        logic [4:0]       wr;
        logic             ra;
        logic             wa;
        logic [1:0]       dir;
        logic             gr;
        logic             gw;
        logic             bz;
        logic [CNT_W-1:0] rc;
        logic [CNT_W-1:0] wc;
        logic [3:0]       req;
    } vec_t;

    localparam int NV = 26;
    // rd, wr, rd_ack, wr_ack | dir, grant_rd, grant_wr, busy, rd_cnt, wr_cnt | requirement
    localparam vec_t VEC [NV] = '{
        '{5'd0, 5'd0,  1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 6'd0, 6'd0, 4'd3},  // R3 idle
        '{5'd3, 5'd2,  1'b1, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 6'd0, 6'd0, 4'd3},  // R3
        '{5'd3, 5'd11, 1'b1, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 6'd1, 6'd0, 4'd10}, // R10
        '{5'd3, 5'd12, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 6'd2, 6'd0, 4'd4},  // R4
        '{5'd3, 5'd12, 1'b1, 1'b1, 2'd1, 1'b0, 1'b0, 1'b1, 6'd2, 6'd0, 4'd6},  // R6, R10 ack ignored
        '{5'd3, 5'd12, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 1'b1, 6'd2, 6'd0, 4'd6},  // R6
        '{5'd3, 5'd12, 1'b0, 1'b1, 2'd2, 1'b0, 1'b1, 1'b0, 6'd2, 6'd0, 4'd7},  // R7
        '{5'd3, 5'd3,  1'b0, 1'b1, 2'd2, 1'b0, 1'b1, 1'b0, 6'd2, 6'd1, 4'd8},  // R8 batch short
        '{5'd3, 5'd2,  1'b0, 1'b0, 2'd2, 1'b0, 1'b1, 1'b0, 6'd2, 6'd2, 4'd8},  // R8
        '{5'd3, 5'd2,  1'b0, 1'b1, 2'd2, 1'b0, 1'b1, 1'b0, 6'd2, 6'd2, 4'd10}, // R10
        '{5'd3, 5'd5,  1'b0, 1'b0, 2'd2, 1'b0, 1'b1, 1'b0, 6'd2, 6'd3, 4'd8},  // R8 above low mark
        '{5'd3, 5'd1,  1'b0, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 6'd2, 6'd3, 4'd8},  // R8 switch
        '{5'd3, 5'd1,  1'b0, 1'b0, 2'd3, 1'b0, 1'b0, 1'b1, 6'd2, 6'd3, 4'd9},  // R9
        '{5'd3, 5'd1,  1'b0, 1'b0, 2'd3, 1'b0, 1'b0, 1'b1, 6'd2, 6'd3, 4'd9},  // R9
        '{5'd3, 5'd1,  1'b0, 1'b0, 2'd3, 1'b0, 1'b0, 1'b1, 6'd2, 6'd3, 4'd9},  // R9
        '{5'd0, 5'd1,  1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 6'd0, 6'd3, 4'd5},  // R5, R10 clear
        '{5'd0, 5'd1,  1'b1, 1'b0, 2'd1, 1'b0, 1'b0, 1'b1, 6'd0, 6'd3, 4'd6},  // R6
        '{5'd0, 5'd1,  1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 1'b1, 6'd0, 6'd3, 4'd6},  // R6
        '{5'd0, 5'd1,  1'b0, 1'b1, 2'd2, 1'b0, 1'b1, 1'b0, 6'd0, 6'd0, 4'd10}, // R10 clear
        '{5'd0, 5'd0,  1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 6'd0, 6'd1, 4'd8},  // R8 no reads
        '{5'd2, 5'd0,  1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 6'd0, 6'd1, 4'd8},  // R8 empty
        '{5'd2, 5'd0,  1'b0, 1'b0, 2'd3, 1'b0, 1'b0, 1'b1, 6'd0, 6'd1, 4'd9},  // R9
        '{5'd2, 5'd0,  1'b0, 1'b0, 2'd3, 1'b0, 1'b0, 1'b1, 6'd0, 6'd1, 4'd9},  // R9
        '{5'd2, 5'd0,  1'b0, 1'b0, 2'd3, 1'b0, 1'b0, 1'b1, 6'd0, 6'd1, 4'd9},  // R9
        '{5'd2, 5'd0,  1'b1, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 6'd0, 6'd1, 4'd2},  // R2
        '{5'd2, 5'd0,  1'b1, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 6'd1, 6'd1, 4'd3}   // R3
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [4:0]       rd_occ = '0;
    logic [4:0]       wr_occ = '0;
    logic             rd_ack = 1'b0;
    logic             wr_ack = 1'b0;
    logic [1:0]       bus_dir;
    logic             grant_rd;
    logic             grant_wr;
    logic             turn_busy;
    logic [CNT_W-1:0] rd_cnt;
    logic [CNT_W-1:0] wr_cnt;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    rw_turn_arbiter u_rw_turn_arbiter (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_occ   (rd_occ),
        .wr_occ   (wr_occ),
        .rd_ack   (rd_ack),
        .wr_ack   (wr_ack),
        .bus_dir  (bus_dir),
        .grant_rd (grant_rd),
        .grant_wr (grant_wr),
        .turn_busy(turn_busy),
        .rd_cnt   (rd_cnt),
        .wr_cnt   (wr_cnt)
    );

    function automatic logic [16:0] pack_out();
        return {bus_dir, grant_rd, grant_wr, turn_busy, rd_cnt, wr_cnt};
    endfunction

    task automatic check(input string tag, input logic [16:0] exp);
        n_chk++;
        if (pack_out() !== exp) begin
            n_fail++;
            $display("FAIL %s: actual dir/grd/gwr/busy/rc/wc=%h expected %h",
                     tag, pack_out(), exp);
        end
    endtask

    task automatic drive(input logic [4:0] r, input logic [4:0] w,
                         input logic ra, input logic wa);
        @(negedge clk);
        rd_occ = r;
        wr_occ = w;
        rd_ack = ra;
        wr_ack = wa;
        #1;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        // R1 reset state
        repeat (3) @(posedge clk);
        drive(5'd0, 5'd0, 1'b0, 1'b0);
        rst_n = 1'b1;
        check("R1 reset state", {2'd0, 1'b0, 1'b0, 1'b0, 6'd0, 6'd0});

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].rd, VEC[i].wr, VEC[i].ra, VEC[i].wa);
            check($sformatf("R%0d vector %0d", VEC[i].req, i),
                  {VEC[i].dir, VEC[i].gr, VEC[i].gw, VEC[i].bz,
                   VEC[i].rc, VEC[i].wc});
        end

        // R4 full write queue blocks pending reads
        drive(5'd16, 5'd16, 1'b1, 1'b0);
        check("R4 full write queue", {2'd0, 1'b0, 1'b0, 1'b0, 6'd2, 6'd1});

        // R6 enter write phase, then R1 reset in mid-phase
        drive(5'd16, 5'd16, 1'b0, 1'b0);
        drive(5'd16, 5'd16, 1'b0, 1'b0);
        drive(5'd0, 5'd8, 1'b0, 1'b1);
        check("R6 then write", {2'd2, 1'b0, 1'b1, 1'b0, 6'd2, 6'd0});
        drive(5'd0, 5'd8, 1'b0, 1'b1);
        check("R10 write count", {2'd2, 1'b0, 1'b1, 1'b0, 6'd2, 6'd1});
        rst_n = 1'b0;
        drive(5'd0, 5'd8, 1'b0, 1'b0);
        drive(5'd0, 5'd0, 1'b0, 1'b0);
        check("R1 mid-run reset", {2'd0, 1'b0, 1'b0, 1'b0, 6'd0, 6'd0});
        rst_n = 1'b1;
        drive(5'd1, 5'd0, 1'b1, 1'b0);
        check("R3 after reset", {2'd0, 1'b1, 1'b0, 1'b0, 6'd0, 6'd0});

        finish_run();
    end

endmodule